// File: doc/BRIEF.md
# AES Forward Key Schedule Round Unit

This unit produces one round of the forward AES key expansion for each accepted request. A single input chooses between the 128-bit schedule and the 256-bit schedule. The caller supplies the current 128-bit round key and, in 256-bit mode, the round key from the round before it. A 5-bit immediate carries the round number. The unit returns the next 128-bit round key in a register one clock after the request. Sequencing the schedule from round to round and storing keys are left to the caller, which feeds each result back in as the next current key.

Keys are handled as four 32-bit words. Word j sits at bits 32j+31:32j, so word 3 is the most significant. Inside a word, byte 0 is bits 7:0 and is the first byte of the AES column. The first new word is computed from the top word of the current key. Every later word is the XOR of a reference word and the new word just below it. The reference words come from the current key in 128-bit mode and from the previous key in 256-bit mode.

Top module: `aes_ks_round`

## Requirements
- R1: While rst_n is low, and until the first accepted request, out_valid is 0 and next_key is all zeros.
- R2: A request with in_valid high at a rising clock edge makes out_valid high for exactly the following cycle. Without a request, out_valid is low.
- R3: next_key keeps its value through every cycle in which no request is taken.
- R4: For j = 1..3, new word j equals reference word j XOR new word j-1. The reference key is cur_key when wide_mode=0 and prev_key when wide_mode=1.
- R5: When wide_mode=0, new word 0 equals cur_key word 0 XOR SubWord(RotWord(cur_key word 3)) XOR RC(r). RotWord maps a word w to {w[7:0], w[31:8]}. The constant RC is XORed into bits 7:0 only.
- R6: RC(1..10) equals 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 (hex).
- R7: When wide_mode=1 and the round number r is even, new word 0 equals prev_key word 0 XOR SubWord(RotWord(cur_key word 3)) XOR RC(r/2).
- R8: When wide_mode=1 and r is odd, new word 0 equals prev_key word 0 XOR SubWord(cur_key word 3). No constant is added.
- R9: round_imm[4] has no effect on the result in either mode.
- R10: When wide_mode=0, r is round_imm[3:0] if that value lies in 1..10. Otherwise r is that value with bit 3 inverted (0→8, 11→3, 12..15→4..7).
- R11: When wide_mode=1, r is round_imm[3:0] if that value lies in 2..14. Otherwise r is that value with bit 3 inverted (0→8, 1→9, 15→7).
- R12: SubWord applies the AES S-box to each byte. The S-box takes the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0 maps to 0), then applies the affine map b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63.
- R13: Start from the standard 128-bit test key 2b7e1516 28aed2a6 abf71588 09cf4f3c (bytes in order) and feed each result back as cur_key for rounds 1 to 10. The last result is d014f9a8 c9ee2589 e13f0cc8 b6630ca6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| wide_mode | input | 1 | 0 selects the 128-bit schedule, 1 selects the 256-bit schedule |
| round_imm | input | 5 | Round-number immediate |
| cur_key | input | 128 | Current round key |
| prev_key | input | 128 | Previous round key, used in 256-bit mode |
| out_valid | output | 1 | Result strobe |
| next_key | output | 128 | Registered next round key |

## Verification
Only one pipeline register holds state, so a wrong value there shows up at next_key in the cycle right after the request. A bad S-box entry, constant or round mapping damages word 0 first. The word chain then carries the damage into all four words, so even one wrong byte in the first word makes every word of the result wrong. Because of this the ten-round chained test magnifies any single-round error. A strobe or hold fault shows up one cycle after a request, or after an idle cycle, as a wrong out_valid or a change in next_key.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [7:0]  INV_EXP = 8'd254;
    localparam logic [7:0]  AFFINE_C = 8'h63;
    localparam logic [7:0]  REDUCE_POLY = 8'h1b;

    typedef enum logic {
        KS_128 = 1'b0,
        KS_256 = 1'b1
    } ks_mode_e;

    typedef struct packed {
        logic [3:0] rnd;
        logic       do_rot;
        logic [7:0] rc;
    } round_ctl_t;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? REDUCE_POLY : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // x^254 is the field inverse for nonzero x and yields 0 for x = 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] res;
        logic [7:0] base;
        res  = 8'h01;
        base = a;
        for (int i = 0; i < 8; i++) begin
            if (INV_EXP[i]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    // RC(k) = x^(k-1); index 0 gives 0
    function automatic logic [7:0] rcon(input logic [3:0] idx);
        logic [7:0] c;
        c = 8'h01;
        for (int i = 1; i < 16; i++) begin
            if (i < int'(idx)) c = xtime(c);
        end
        return (idx == 4'd0) ? 8'h00 : c;
    endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox
    import aes_ks_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    logic [BYTE_W-1:0] inv;

    always_comb begin
        inv  = gf_inv(din);
        dout = inv
             ^ {inv[6:0], inv[7]}
             ^ {inv[5:0], inv[7:6]}
             ^ {inv[4:0], inv[7:5]}
             ^ {inv[3:0], inv[7:4]}
             ^ AFFINE_C;
    end
endmodule

// File: rtl/aes_ks_sub_word.sv
module aes_ks_sub_word
    import aes_ks_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic [WORD_W-1:0] win,
    output logic [WORD_W-1:0] wout
);
    localparam int unsigned NBYTES = WORD_W / BYTE_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        aes_ks_sbox i_sbox (
            .din  (win[b*BYTE_W +: BYTE_W]),
            .dout (wout[b*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/aes_ks_round_sel.sv
module aes_ks_round_sel
    import aes_ks_pkg::*;
(
    input  logic       wide_mode,
    input  logic [4:0] round_imm,
    output round_ctl_t ctl
);
    localparam logic [3:0] LO_128 = 4'd1;
    localparam logic [3:0] HI_128 = 4'd10;
    localparam logic [3:0] LO_256 = 4'd2;
    localparam logic [3:0] HI_256 = 4'd14;

    ks_mode_e   mode;
    logic [3:0] raw;
    logic       outside;

    always_comb begin
        mode = ks_mode_e'(wide_mode);
        raw  = round_imm[3:0];
        if (mode == KS_256) outside = (raw < LO_256) || (raw > HI_256);
        else                outside = (raw < LO_128) || (raw > HI_128);
        ctl.rnd = outside ? {~raw[3], raw[2:0]} : raw;
        if (mode == KS_256) begin
            ctl.do_rot = ~ctl.rnd[0];
            ctl.rc     = ctl.rnd[0] ? 8'h00 : rcon({1'b0, ctl.rnd[3:1]});
        end else begin
            ctl.do_rot = 1'b1;
            ctl.rc     = rcon(ctl.rnd);
        end
    end
endmodule

// File: rtl/aes_ks_chain.sv
module aes_ks_chain #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NWORDS = 4,
    localparam int unsigned KEY_W = WORD_W * NWORDS
) (
    input  logic [WORD_W-1:0] head,
    input  logic [KEY_W-1:0]  ref_key,
    output logic [KEY_W-1:0]  key_out
);
    logic [WORD_W-1:0] w [NWORDS];

    assign w[0] = ref_key[WORD_W-1:0] ^ head;

    for (genvar j = 1; j < NWORDS; j++) begin : g_word
        assign w[j] = ref_key[j*WORD_W +: WORD_W] ^ w[j-1];
    end

    for (genvar j = 0; j < NWORDS; j++) begin : g_pack
        assign key_out[j*WORD_W +: WORD_W] = w[j];
    end
endmodule

// File: rtl/aes_ks_round.sv
module aes_ks_round
    import aes_ks_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NWORDS = 4,
    localparam int unsigned KEY_W = WORD_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              wide_mode,
    input  logic [4:0]        round_imm,
    input  logic [KEY_W-1:0]  cur_key,
    input  logic [KEY_W-1:0]  prev_key,
    output logic              out_valid,
    output logic [KEY_W-1:0]  next_key
);
    typedef struct packed {
        logic             vld;
        logic [KEY_W-1:0] key;
    } state_t;

    state_t            st_d, st_q;
    round_ctl_t        ctl;
    logic [WORD_W-1:0] top_word;
    logic [WORD_W-1:0] sub_in;
    logic [WORD_W-1:0] sub_out;
    logic [WORD_W-1:0] head;
    logic [KEY_W-1:0]  ref_key;
    logic [KEY_W-1:0]  key_new;

    aes_ks_round_sel i_sel (
        .wide_mode (wide_mode),
        .round_imm (round_imm),
        .ctl       (ctl)
    );

    always_comb begin
        top_word = cur_key[KEY_W-1 -: WORD_W];
        sub_in   = ctl.do_rot ? {top_word[BYTE_W-1:0], top_word[WORD_W-1:BYTE_W]}
                              : top_word;
        ref_key  = (ks_mode_e'(wide_mode) == KS_256) ? prev_key : cur_key;
    end

    aes_ks_sub_word #(.WORD_W(WORD_W)) i_sub (
        .win  (sub_in),
        .wout (sub_out)
    );

    assign head = sub_out ^ {{(WORD_W-BYTE_W){1'b0}}, ctl.rc};

    aes_ks_chain #(.WORD_W(WORD_W), .NWORDS(NWORDS)) i_chain (
        .head    (head),
        .ref_key (ref_key),
        .key_out (key_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.key = key_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign next_key  = st_q.key;
endmodule

// File: rtl/aes_ks_round_chk.sv
module aes_ks_round_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NWORDS = 4,
    localparam int unsigned KEY_W = WORD_W * NWORDS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             wide_mode,
    input logic [KEY_W-1:0] cur_key,
    input logic [KEY_W-1:0] prev_key,
    input logic             out_valid,
    input logic [KEY_W-1:0] next_key
);
    logic [KEY_W-1:0] ref_in;
    assign ref_in = wide_mode ? prev_key : cur_key;

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!out_valid && next_key == '0)); // R1
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(next_key)); // R3
    AST_WORD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((next_key[KEY_W-1:WORD_W] ^ next_key[KEY_W-WORD_W-1:0]) == $past(ref_in[KEY_W-1:WORD_W]))); // R4
endmodule

bind aes_ks_round aes_ks_round_chk #(.WORD_W(WORD_W), .NWORDS(NWORDS)) i_aes_ks_round_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wide_mode (wide_mode),
    .cur_key   (cur_key),
    .prev_key  (prev_key),
    .out_valid (out_valid),
    .next_key  (next_key)
);

// File: tb/test_aes_ks_round.sv
`timescale 1ns/1ps
module test_aes_ks_round;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         wide_mode = 1'b0;
    logic [4:0]   round_imm = '0;
    logic [127:0] cur_key = '0;
    logic [127:0] prev_key = '0;
    logic         out_valid;
    logic [127:0] next_key;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    logic [7:0] sb [256];

    always #5 clk = ~clk;

    aes_ks_round i_aes_ks_round (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_mode(wide_mode),
        .round_imm(round_imm), .cur_key(cur_key), .prev_key(prev_key),
        .out_valid(out_valid), .next_key(next_key)
    );

    // ---------------- bench-side reference ----------------
    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] b_rc(input int k);
        logic [7:0] c = 8'h01;
        for (int i = 1; i < k; i++) c = b_mul(c, 8'h02);
        return c;
    endfunction

    function automatic int b_round(input logic wide, input logic [4:0] imm);
        int r = int'(imm[3:0]);
        if (!wide && (r < 1 || r > 10)) r = r ^ 8;
        if (wide && (r < 2 || r > 14)) r = r ^ 8;
        return r;
    endfunction

    function automatic logic [31:0] b_sub(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    function automatic logic [127:0] b_model(input logic wide, input logic [4:0] imm,
                                             input logic [127:0] cur, input logic [127:0] prv);
        int r = b_round(wide, imm);
        logic [31:0] t = cur[127:96];
        logic [31:0] f;
        logic [127:0] rk = wide ? prv : cur;
        logic [31:0] w [4];
        if (!wide)          f = b_sub({t[7:0], t[31:8]}) ^ {24'h0, b_rc(r)};
        else if (r % 2 == 0) f = b_sub({t[7:0], t[31:8]}) ^ {24'h0, b_rc(r / 2)};
        else                f = b_sub(t);
        w[0] = rk[31:0] ^ f;
        for (int j = 1; j < 4; j++) w[j] = rk[32*j +: 32] ^ w[j-1];
        return {w[3], w[2], w[1], w[0]};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // request: drive at negedge, result sampled at following negedge
    task automatic do_round(input logic wide, input logic [4:0] imm,
                            input logic [127:0] cur, input logic [127:0] prv,
                            output logic [127:0] res);
        @(negedge clk);
        wide_mode = wide; round_imm = imm; cur_key = cur; prev_key = prv; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 strobe after request", 128'(out_valid), 128'd1);
        res = next_key;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 out_valid in reset", 128'(out_valid), 128'd0);
        check("R1 next_key in reset", next_key, 128'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 128'(out_valid), 128'd0);
        check("R1 next_key after reset", next_key, 128'd0);
    endtask

    task automatic t_sbox_table();
        check("R12 sbox 00", 128'(sb[8'h00]), 128'h63);
        check("R12 sbox 53", 128'(sb[8'h53]), 128'hed);
    endtask

    task automatic t_kat128();
        logic [127:0] k = {32'h3c4fcf09, 32'h8815f7ab, 32'ha6d2ae28, 32'h16157e2b};
        logic [127:0] res;
        for (int r = 1; r <= 10; r++) begin
            do_round(1'b0, 5'(r), k, 128'h0, res);
            check($sformatf("R5 R6 R12 round %0d", r), res, b_model(1'b0, 5'(r), k, 128'h0));
            if (r == 1) check("R5 round1 word0", 128'(res[31:0]), 128'h17fefaa0);
            k = res;
        end
        check("R13 final key", k, {32'ha60c63b6, 32'hc80c3fe1, 32'h8925eec9, 32'ha8f914d0});
    endtask

    task automatic t_kat256();
        logic [127:0] p = {32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100};
        logic [127:0] c = {32'h1f1e1d1c, 32'h1b1a1918, 32'h17161514, 32'h13121110};
        logic [127:0] r2, r3;
        do_round(1'b1, 5'd2, c, p, r2);
        check("R7 R4 256 round 2", r2, {32'h9cc072a5, 32'h93ce7fa9, 32'h98c476a1, 32'h9fc273a5});
        do_round(1'b1, 5'd3, r2, c, r3);
        check("R8 R4 256 round 3", r3, {32'hdeba4006, 32'hc1a45d1a, 32'hdabe4402, 32'hcda85116});
    endtask

    task automatic t_rcon_list();
        logic [7:0] exp_rc [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
        logic [127:0] res;
        // zero key: word0 = sbox(0) repeated ^ RC
        for (int r = 1; r <= 10; r++) begin
            do_round(1'b0, 5'(r), 128'h0, 128'h0, res);
            check($sformatf("R6 RC(%0d)", r), 128'(res[31:0]), 128'({24'h636363, 8'h63 ^ exp_rc[r-1]}));
        end
    endtask

    task automatic t_random(input logic wide, input int n);
        logic [127:0] c, p, res;
        logic [4:0] imm;
        for (int i = 0; i < n; i++) begin
            c = {$urandom, $urandom, $urandom, $urandom};
            p = {$urandom, $urandom, $urandom, $urandom};
            imm = 5'($urandom);
            do_round(wide, imm, c, p, res);
            check(wide ? "R4 R7 R8 R11 random 256" : "R4 R5 R10 random 128",
                  res, b_model(wide, imm, c, p));
        end
    endtask

    task automatic t_imm4();
        logic [127:0] c = {32'hdeadbeef, 32'h01234567, 32'h89abcdef, 32'h55aa33cc};
        logic [127:0] a, b;
        for (int w = 0; w < 2; w++) begin
            do_round(w[0], 5'h05, c, ~c, a);
            do_round(w[0], 5'h15, c, ~c, b);
            check("R9 imm[4] ignored", b, a);
        end
    endtask

    task automatic t_range();
        logic [127:0] c = {32'h0badf00d, 32'h12345678, 32'hcafef00d, 32'h9abcdef0};
        logic [127:0] a, b;
        int m128 [6] = '{0, 11, 12, 13, 14, 15};
        int t128 [6] = '{8, 3, 4, 5, 6, 7};
        int m256 [3] = '{0, 1, 15};
        int t256 [3] = '{8, 9, 7};
        for (int i = 0; i < 6; i++) begin
            do_round(1'b0, 5'(m128[i]), c, 128'h0, a);
            do_round(1'b0, 5'(t128[i]), c, 128'h0, b);
            check($sformatf("R10 imm %0d maps to %0d", m128[i], t128[i]), a, b);
        end
        for (int i = 0; i < 3; i++) begin
            do_round(1'b1, 5'(m256[i]), c, ~c, a);
            do_round(1'b1, 5'(t256[i]), c, ~c, b);
            check($sformatf("R11 imm %0d maps to %0d", m256[i], t256[i]), a, b);
        end
    endtask

    task automatic t_hold();
        logic [127:0] res;
        do_round(1'b0, 5'd4, {4{32'h11223344}}, 128'h0, res);
        cur_key = ~cur_key; round_imm = 5'd9; wide_mode = 1'b1;
        @(negedge clk);
        check("R2 no strobe when idle", 128'(out_valid), 128'd0);
        check("R3 key held idle 1", next_key, res);
        @(negedge clk);
        check("R3 key held idle 2", next_key, res);
    endtask

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            for (int y = 1; y < 256; y++) if (b_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
                    ^ {inv[3:0], inv[7:4]} ^ 8'h63;
            sb[x] = s;
        end
        @(negedge clk);
        t_reset();
        t_sbox_table();
        t_kat128();
        t_kat256();
        t_rcon_list();
        t_random(1'b0, 40);
        t_random(1'b1, 40);
        t_imm4();
        t_range();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule